// File: doc/BRIEF.md
# Latched Counter with Byte-Serial Readout

This block counts falling edges on an external count input. It runs either as one wide binary up counter or as two independent half-width counters, each with its own count input. All external inputs are asynchronous to the block. They are brought into the system clock domain by a synchronizer, and their edges are detected synchronously.

A rising edge on the snapshot strobe copies the whole count into a holding register, together with an 8-bit byte taken from an outside prescaler. Because the whole count is copied in one clock cycle, the readout that follows is coherent even while counting goes on. The most significant bit of that prescaler byte is the synchronized level of the primary count input.

The held value leaves one byte at a time on an 8-bit three-state bus. Each rising edge of a scan strobe advances the readout to the next byte. A chain-enable input and a chain-done output let several of these blocks share one bus: each block presents its bytes in turn and then hands over to the next block in the chain. After reset, count edges are ignored for a programmable number of clocks, which models the minimum recovery time.

Top module: `latched_byte_counter`

## Requirements
- R1: The counter advances by exactly one for each high-to-low transition of a count input. A low-to-high transition leaves the count unchanged.
- R2: When `split_mode` is 0, the count input `count_b` has no effect. A carry out of the lower half (all ones on a count_a fall) increments the upper half.
- R3: When `split_mode` is 0, the full counter wraps from all ones to all zeros on the next count_a fall.
- R4: When `split_mode` is 1, count_a falls increment only the lower half and count_b falls increment only the upper half. The lower half wraps from all ones to zero and leaves the upper half unchanged.
- R5: A rising edge of `latch_stb` copies the counter and the prescaler byte into the snapshot. Counting after that edge leaves the snapshot bytes unchanged until the next rising edge of `latch_stb`.
- R6: The snapshot's prescaler byte holds `ext_lo` in bits 6..0 and the synchronized level of `count_a` in bit 7.
- R7: Readout slot 0 is the prescaler byte. Slots 1 to N are the counter bytes, least significant first. Each rising edge of `scan_stb` advances one slot while the block is enabled. Scan edges seen while `casc_in` is 0 have no effect.
- R8: The last slot is followed by a scan edge. That edge raises `casc_out` and drops `bus_oe`. Taking `casc_in` low clears `casc_out` and returns the readout to slot 0.
- R9: `bus_oe` is 0 whenever `casc_in` is 0, and `data_o` is high-impedance whenever `bus_oe` is 0.
- R10: For the first RECOVER_CYC clocks after reset is released, falls on the count inputs are not counted.
- R11: Reset (`rst_n` low) clears the counter, the snapshot, the readout slot and `casc_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| count_a | input | 1 | Primary count input; falls are counted |
| count_b | input | 1 | Upper-half count input, used in split mode only |
| split_mode | input | 1 | 1: two independent halves; 0: one wide counter |
| ext_lo | input | 7 | Lower seven bits of the outside prescaler byte |
| latch_stb | input | 1 | Rising edge captures the snapshot |
| scan_stb | input | 1 | Rising edge advances the readout slot |
| casc_in | input | 1 | Chain enable from the previous block |
| casc_out | output | 1 | Chain enable to the next block; set when readout is finished |
| bus_oe | output | 1 | High while this block drives the bus |
| data_o | output | 8 | Three-state readout byte |

## Verification
On every cycle, the checker checks these properties:
- the bus is released whenever the block is not enabled or has finished its readout;
- the lower half only ever steps by one;
- a carry reaches the upper half in wide mode, and nothing reaches it in split mode without a count_b fall;
- the counter is frozen during recovery;
- the snapshot moves only on a strobe edge.

Some behaviour can only be shown by the bench's scenarios. These are the byte order on the bus, the prescaler byte's bit 7 following the count input, scans ignored while the block is not enabled, the full wrap of the wide counter, and agreement with a reference count under random mixes of edges on both inputs.

// File: rtl/lcb_pkg.sv
package lcb_pkg;
    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned SIG_CNTA  = 0;
    localparam int unsigned SIG_CNTB  = 1;
    localparam int unsigned SIG_LATCH = 2;
    localparam int unsigned SIG_SCAN  = 3;
    localparam int unsigned N_SIG     = 4;

    // readout slots: prescaler byte plus the counter bytes
    function automatic int unsigned slot_count(input int unsigned half_w);
        return (2 * half_w) / BYTE_W + 1;
    endfunction
endpackage

// File: rtl/lcb_sync.sv
module lcb_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] lvl_o
);
    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] sh;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.sh[0] = raw_i;
        for (int i = 1; i < int'(STAGES); i++) begin
            st_d.sh[i] = st_q.sh[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl_o = st_q.sh[STAGES-1];
endmodule

// File: rtl/lcb_count_core.sv
module lcb_count_core #(
    parameter int unsigned HALF_W      = 16,
    parameter int unsigned RECOVER_CYC = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  split_i,
    input  logic                  inc_a_i,
    input  logic                  inc_b_i,
    output logic                  ready_o,
    output logic [2*HALF_W-1:0]   cnt_o
);
    localparam int unsigned RW = $clog2(RECOVER_CYC + 2);
    localparam logic [RW-1:0] REC_END = RW'(RECOVER_CYC);

    typedef struct packed {
        logic [HALF_W-1:0] hi;
        logic [HALF_W-1:0] lo;
        logic [RW-1:0]     rec;
    } core_t;

    core_t st_d, st_q;
    logic  ready;
    logic  carry;

    assign ready = (st_q.rec == REC_END);
    assign carry = &st_q.lo;

    always_comb begin
        st_d = st_q;
        if (!ready) begin
            st_d.rec = st_q.rec + RW'(1);
        end else begin
            if (inc_a_i) begin
                st_d.lo = st_q.lo + HALF_W'(1);
            end
            if (split_i) begin
                if (inc_b_i) st_d.hi = st_q.hi + HALF_W'(1);
            end else if (inc_a_i && carry) begin
                st_d.hi = st_q.hi + HALF_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ready_o = ready;
    assign cnt_o   = {st_q.hi, st_q.lo};
endmodule

// File: rtl/lcb_byte_mux.sv
module lcb_byte_mux #(
    parameter int unsigned HALF_W = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [lcb_pkg::BYTE_W*lcb_pkg::slot_count(HALF_W)-1:0] live_i,
    input  logic                              take_i,
    input  logic                              step_i,
    input  logic                              casc_in,
    output logic [lcb_pkg::BYTE_W*lcb_pkg::slot_count(HALF_W)-1:0] snap_o,
    output logic [lcb_pkg::BYTE_W-1:0]        byte_o,
    output logic                              oe_o,
    output logic                              done_o
);
    import lcb_pkg::*;
    localparam int unsigned NB     = slot_count(HALF_W);
    localparam int unsigned SNAP_W = BYTE_W * NB;
    localparam int unsigned PW     = $clog2(NB);
    localparam logic [PW-1:0] LAST = PW'(NB - 1);

    typedef struct packed {
        logic [SNAP_W-1:0] snap;
        logic [PW-1:0]     ptr;
        logic              done;
    } mux_t;

    mux_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (take_i) begin
            st_d.snap = live_i;
        end
        if (!casc_in) begin
            st_d.ptr  = '0;
            st_d.done = 1'b0;
        end else if (step_i && !st_q.done) begin
            if (st_q.ptr == LAST) begin
                st_d.ptr  = '0;
                st_d.done = 1'b1;
            end else begin
                st_d.ptr = st_q.ptr + PW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign snap_o = st_q.snap;
    assign byte_o = st_q.snap[int'(st_q.ptr)*BYTE_W +: BYTE_W];
    assign oe_o   = casc_in & ~st_q.done;
    assign done_o = st_q.done;
endmodule

// File: rtl/latched_byte_counter.sv
module latched_byte_counter #(
    parameter int unsigned HALF_W      = 16,
    parameter int unsigned RECOVER_CYC = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       count_a,
    input  logic       count_b,
    input  logic       split_mode,
    input  logic [6:0] ext_lo,
    input  logic       latch_stb,
    input  logic       scan_stb,
    input  logic       casc_in,
    output logic       casc_out,
    output logic       bus_oe,
    output logic [7:0] data_o
);
    import lcb_pkg::*;
    localparam int unsigned CNT_W  = 2 * HALF_W;
    localparam int unsigned NB     = slot_count(HALF_W);
    localparam int unsigned SNAP_W = BYTE_W * NB;

    typedef struct packed {
        logic [N_SIG-1:0] prev;
    } edge_t;

    edge_t            edg_d, edg_q;
    logic [N_SIG-1:0] raw, lvl, evt;
    logic             fall_a, fall_b, latch_rise, scan_rise;
    logic             cnt_ready;
    logic [CNT_W-1:0] cnt_q;
    logic [SNAP_W-1:0] snap_q;
    logic [7:0]       mux_byte;

    assign raw = {scan_stb, latch_stb, count_b, count_a};

    lcb_sync #(.WIDTH(N_SIG), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_i (raw),
        .lvl_o (lvl)
    );

    always_comb begin
        edg_d      = edg_q;
        edg_d.prev = lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) edg_q <= '0;
        else        edg_q <= edg_d;
    end

    // counts react to falls, strobes to rises
    genvar g;
    generate
        for (g = 0; g < int'(N_SIG); g++) begin : g_evt
            if (g == int'(SIG_CNTA) || g == int'(SIG_CNTB)) begin : g_fall
                assign evt[g] = edg_q.prev[g] & ~lvl[g];
            end else begin : g_rise
                assign evt[g] = ~edg_q.prev[g] & lvl[g];
            end
        end
    endgenerate

    assign fall_a     = evt[SIG_CNTA] & cnt_ready;
    assign fall_b     = evt[SIG_CNTB] & cnt_ready;
    assign latch_rise = evt[SIG_LATCH];
    assign scan_rise  = evt[SIG_SCAN];

    lcb_count_core #(.HALF_W(HALF_W), .RECOVER_CYC(RECOVER_CYC)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .split_i (split_mode),
        .inc_a_i (fall_a),
        .inc_b_i (fall_b),
        .ready_o (cnt_ready),
        .cnt_o   (cnt_q)
    );

    lcb_byte_mux #(.HALF_W(HALF_W)) u_mux (
        .clk     (clk),
        .rst_n   (rst_n),
        .live_i  ({cnt_q, lvl[SIG_CNTA], ext_lo}),
        .take_i  (latch_rise),
        .step_i  (scan_rise),
        .casc_in (casc_in),
        .snap_o  (snap_q),
        .byte_o  (mux_byte),
        .oe_o    (bus_oe),
        .done_o  (casc_out)
    );

    assign data_o = bus_oe ? mux_byte : 8'bzzzz_zzzz;
endmodule

// File: rtl/lcb_checker.sv
module lcb_checker #(
    parameter int unsigned HALF_W = 16,
    parameter int unsigned SNAP_W = 40
) (
    input logic                clk,
    input logic                rst_n,
    input logic                casc_in,
    input logic                casc_out,
    input logic                bus_oe,
    input logic                split_mode,
    input logic                ready,
    input logic                fall_a,
    input logic                fall_b,
    input logic                latch_rise,
    input logic [2*HALF_W-1:0] cnt,
    input logic [SNAP_W-1:0]   snap
);
    logic [HALF_W-1:0] lo, hi;
    assign lo = cnt[HALF_W-1:0];
    assign hi = cnt[2*HALF_W-1:HALF_W];

    p_hiz_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !casc_in |-> !bus_oe);

    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        casc_out |-> !bus_oe);

    p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (lo != $past(lo)) |-> (lo == $past(lo) + HALF_W'(1)));

    p_carry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!split_mode && fall_a && (&lo)) |=> (hi == $past(hi) + HALF_W'(1)));

    p_no_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (split_mode && !fall_b) |=> $stable(hi));

    p_recover_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> $stable(cnt));

    p_snap_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_rise |=> $stable(snap));
endmodule

bind latched_byte_counter lcb_checker #(.HALF_W(HALF_W), .SNAP_W(SNAP_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .casc_in    (casc_in),
    .casc_out   (casc_out),
    .bus_oe     (bus_oe),
    .split_mode (split_mode),
    .ready      (cnt_ready),
    .fall_a     (fall_a),
    .fall_b     (fall_b),
    .latch_rise (latch_rise),
    .cnt        (cnt_q),
    .snap       (snap_q)
);

// File: tb/latched_byte_counter_bench.sv
`timescale 1ns/1ps
module latched_byte_counter_bench;
    localparam int unsigned HW  = 8;
    localparam int unsigned REC = 16;
    localparam int unsigned NB  = (2 * HW) / 8 + 1;

    logic clk = 1'b0;
    logic rst_n, count_a, count_b, split_mode, latch_stb, scan_stb, casc_in;
    logic [6:0] ext_lo;
    logic casc_out, bus_oe;
    logic [7:0] data_o;

    int total = 0;
    int bad   = 0;
    logic [HW-1:0] exp_lo, exp_hi;
    logic [8*NB-1:0] exp_snap;

    always #2.5 clk = ~clk;

    latched_byte_counter #(.HALF_W(HW), .RECOVER_CYC(REC)) u_latched_byte_counter (
        .clk(clk), .rst_n(rst_n), .count_a(count_a), .count_b(count_b),
        .split_mode(split_mode), .ext_lo(ext_lo), .latch_stb(latch_stb),
        .scan_stb(scan_stb), .casc_in(casc_in), .casc_out(casc_out),
        .bus_oe(bus_oe), .data_o(data_o)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [8*NB-1:0] model_snap(input logic a_lvl, input logic [6:0] e);
        return {exp_hi, exp_lo, a_lvl, e};
    endfunction

    task automatic model_a();
        if (split_mode) exp_lo = exp_lo + 1'b1;
        else {exp_hi, exp_lo} = {exp_hi, exp_lo} + 1'b1;
    endtask

    task automatic model_b();
        if (split_mode) exp_hi = exp_hi + 1'b1;
    endtask

    task automatic fall_a(input int n);
        for (int i = 0; i < n; i++) begin
            count_a = 1'b0; tick(1); count_a = 1'b1; tick(1);
            model_a();
        end
    endtask

    task automatic fall_b(input int n);
        for (int i = 0; i < n; i++) begin
            count_b = 1'b1; tick(1); count_b = 1'b0; tick(1);
            model_b();
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; count_a = 1'b1; count_b = 1'b0;
        latch_stb = 1'b0; scan_stb = 1'b0; casc_in = 1'b0;
        tick(4);
        rst_n = 1'b1;
        tick(REC + 8);
        exp_lo = '0; exp_hi = '0;
    endtask

    task automatic pulse_latch();
        tick(2);
        latch_stb = 1'b1; tick(3); latch_stb = 1'b0; tick(3);
        exp_snap = model_snap(count_a, ext_lo);
    endtask

    task automatic pulse_scan();
        scan_stb = 1'b1; tick(3); scan_stb = 1'b0; tick(3);
    endtask

    task automatic read_all(input string tag, input logic [8*NB-1:0] want);
        casc_in = 1'b1; tick(1);
        for (int i = 0; i < int'(NB); i++) begin
            check({tag, " R7 oe"}, {31'd0, bus_oe}, 32'd1);
            check({tag, " R7 byte"}, {24'd0, data_o}, {24'd0, want[i*8 +: 8]});
            pulse_scan();
        end
        check({tag, " R8 casc_out"}, {31'd0, casc_out}, 32'd1);
        check({tag, " R8 released"}, {31'd0, bus_oe}, 32'd0);
        casc_in = 1'b0; tick(2);
        check({tag, " R8 casc_out clear"}, {31'd0, casc_out}, 32'd0);
        check({tag, " R9 oe off"}, {31'd0, bus_oe}, 32'd0);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        split_mode = 1'b0; ext_lo = 7'h2a;

        // R10: fall inside the recovery window is not counted
        rst_n = 1'b0; count_a = 1'b1; count_b = 1'b0;
        latch_stb = 1'b0; scan_stb = 1'b0; casc_in = 1'b0;
        tick(4);
        rst_n = 1'b1;
        check("R11 casc_out after reset", {31'd0, casc_out}, 32'd0);
        check("R9 oe with casc_in low", {31'd0, bus_oe}, 32'd0);
        tick(2);
        count_a = 1'b0; tick(1); count_a = 1'b1;
        tick(REC + 8);
        exp_lo = '0; exp_hi = '0;
        casc_in = 1'b1; tick(1);
        check("R11 snapshot clear, slot 0", {24'd0, data_o}, 32'd0);
        casc_in = 1'b0; tick(2);
        pulse_latch();
        read_all("R10 recovery", exp_snap);

        // R1: falls count, rise alone does not
        fall_a(5);
        pulse_latch(); read_all("R1 five falls", exp_snap);
        count_a = 1'b0; tick(3); model_a();
        pulse_latch();
        check("R6 msb low", {31'd0, exp_snap[7]}, 32'd0);
        read_all("R1 fall, R6 msb", exp_snap);
        count_a = 1'b1; tick(3);
        pulse_latch(); read_all("R1 rise ignored", exp_snap);

        // R2: count_b ignored, carry into the upper half
        fall_b(7);
        pulse_latch(); read_all("R2 count_b ignored", exp_snap);
        fall_a(255 - 6);
        pulse_latch(); read_all("R2 low full", exp_snap);
        fall_a(1);
        check("R2 model carry", {16'd0, exp_hi, exp_lo}, 32'h0100);
        pulse_latch(); read_all("R2 carry", exp_snap);

        // R5: snapshot held while counting continues
        ext_lo = 7'h11;
        fall_a(3);
        read_all("R5 held", exp_snap);

        // R7: scans ignored while not enabled
        pulse_latch();
        pulse_scan(); pulse_scan();
        casc_in = 1'b1; tick(1);
        check("R7 scan ignored", {24'd0, data_o}, {24'd0, exp_snap[7:0]});
        casc_in = 1'b0; tick(2);

        // R11: reset mid-run clears counter
        do_reset();
        pulse_latch(); read_all("R11 reset clears", exp_snap);

        // R4: split mode, lower half wraps without carry
        split_mode = 1'b1;
        fall_b(3);
        fall_a(256);
        check("R4 model", {16'd0, exp_hi, exp_lo}, 32'h0300);
        pulse_latch(); read_all("R4 lower wrap", exp_snap);

        // R4: random mix of edges on both inputs
        for (int r = 0; r < 6; r++) begin
            ext_lo = 7'($urandom);
            for (int i = 0; i < 200; i++) begin
                case ($urandom % 3)
                    0: fall_a(1);
                    1: fall_b(1);
                    default: begin
                        count_a = 1'b0; count_b = 1'b1; tick(1);
                        count_a = 1'b1; count_b = 1'b0; tick(1);
                        model_a(); model_b();
                    end
                endcase
            end
            pulse_latch(); read_all("R4 random split", exp_snap);
        end

        // R3: wide counter wraps to zero
        split_mode = 1'b0;
        do_reset();
        fall_a(65536);
        check("R3 model wrap", {16'd0, exp_hi, exp_lo}, 32'd0);
        pulse_latch(); read_all("R3 wrap", exp_snap);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule